// File: doc/BRIEF.md
# Gate-Line Scan Sequencer

This block walks a single selection token down the gate lines of an active-matrix panel. The panel uses gate-coupled storage capacitors, so each line is refreshed by a gate pulse and its neighbour receives a pre-pulse. The token chain has one stage per line: 240 gate lines plus one trailing line that only ever receives a pre-pulse. For every line the block drives a 3-bit level-select code to an analog switch matrix. That matrix picks one of five levels: the gate-on high level, a positive pre-pulse level, the gate-off low level, a negative pre-pulse level, or ground.

All logic runs on a fast system clock. Both row clocks and the frame-start strobe are sampled as synchronous inputs. Each rising edge of the primary row clock moves the token one line. A frame-start seen on that edge reloads the token at line 1 and latches the programmed line count. The secondary row clock sets the window in which the gate-on and pre-pulse levels are applied. The polarity of the pre-pulse is taken once per row period. When the token leaves the last programmed line, a one-row-period end-of-frame flag is raised.

Top module: `gate_scan_seq`

## Requirements
- R1: While `rst_n` is low, every line's select code is 0 (ground) and `frame_done` is 0. After release, every line up to the full count shows code 3 (gate-off), and no line holds the token.
- R2: A rising edge of `row_clk_a` with `frame_start` high puts the token on line 1 (bit field 0 of `row_sel`). On the same edge it latches the line count, whatever the token's previous position.
- R3: Each later rising edge of `row_clk_a` moves the token exactly one line toward the highest-numbered line. At most one line holds the token.
- R4: The line holding the token shows code 1 (gate-on) while `row_clk_b` is high and code 3 while it is low. Codes appear one system clock after the inputs are sampled.
- R5: The line just after the token shows the pre-pulse code while `row_clk_b` is high. That code is 2 (positive) when the captured polarity is 1 and 4 (negative) when it is 0. The line shows code 3 while `row_clk_b` is low.
- R6: Polarity is captured from `pulse_pol` only on a `row_clk_a` rising edge. Changing `pulse_pol` later in the row period has no effect on the codes.
- R7: The latched count is `active_rows`, with 0 treated as 1 and values above 241 treated as 241. Lines numbered above the count show code 0 at all times and never receive the token or a pre-pulse.
- R8: Line 241 never shows code 1. With the token on it, the line shows code 3.
- R9: `frame_done` is 1 for exactly the row period after the token leaves the last programmed line. From then on, every programmed line shows code 3 until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears the chain and grounds all lines |
| row_clk_a | input | 1 | Primary row clock; rising edge advances the token |
| row_clk_b | input | 1 | Secondary row clock; high selects the drive window |
| frame_start | input | 1 | Reloads the token at line 1 on the next primary rising edge |
| pulse_pol | input | 1 | Pre-pulse polarity, 1 = positive level, 0 = negative level |
| active_rows | input | 8 | Programmed number of active lines, 1 to 241 |
| row_sel | output | 723 | Per-line 3-bit select codes, line n at bits [3n-1:3n-3] |
| frame_done | output | 1 | End-of-frame flag, one row period long |

## Verification
The hardest states to reach are the two ends of the chain. The first is the token sitting on line 241, where the gate-on code must be withheld. The second is the period just after the token drops off the last programmed line, where no line may carry a pre-pulse. Full frames at counts 1, 120 and 241 reach both ends, as does a programmed count of 0 that must behave as 1. A frame start issued mid-scan, and a reset asserted with the drive window open, reach the reload and clearing paths. Every row step flips `pulse_pol` after its capture edge, so the polarity latch is tested in every row of every frame.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_GND    = 3'd0,
        SEL_ON     = 3'd1,
        SEL_PP_POS = 3'd2,
        SEL_OFF    = 3'd3,
        SEL_PP_NEG = 3'd4
    } sel_code_e;
endpackage

// File: rtl/gsc_row_edge.sv
module gsc_row_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic row_clk_a,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = row_clk_a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = row_clk_a & ~st_q.prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3
endmodule

// File: rtl/gsc_token_chain.sv
module gsc_token_chain #(
    parameter int ROWS = 241
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise,
    input  logic                         frame_start,
    input  logic                         pulse_pol,
    input  logic [$clog2(ROWS+1)-1:0]    active_rows,
    output logic [ROWS-1:0]              tok,
    output logic [ROWS-1:0]              act_mask,
    output logic                         pol,
    output logic                         done
);
    localparam int CNT_W = $clog2(ROWS + 1);

    typedef struct packed {
        logic [ROWS-1:0]  tok;
        logic [CNT_W-1:0] cnt;
        logic             pol;
        logic             done;
    } chain_state_t;

    chain_state_t    st_d, st_q;
    logic [ROWS-1:0] last_hit;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v);
        if (v == '0)                return CNT_W'(1);
        else if (v > CNT_W'(ROWS))  return CNT_W'(ROWS);
        else                        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            act_mask[i] = (i < int'(st_q.cnt));
            last_hit[i] = (i == int'(st_q.cnt) - 1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (rise) begin
            st_d.pol = pulse_pol;
            if (frame_start) begin
                st_d.tok    = ROWS'(1);
                st_d.cnt    = clamp_cnt(active_rows);
                st_d.done   = 1'b0;
            end else begin
                st_d.done = |(st_q.tok & last_hit);
                st_d.tok  = (st_q.tok << 1) & act_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tok  <= '0;
            st_q.cnt  <= CNT_W'(ROWS);
            st_q.pol  <= 1'b0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tok  = st_q.tok;
    assign pol  = st_q.pol;
    assign done = st_q.done;

    AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.tok)); // R3
    AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.tok)); // R3
    AST_START_ROW1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && frame_start) |=> (st_q.tok == ROWS'(1))); // R2
    AST_TOKEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tok & ~act_mask) == '0); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= CNT_W'(1)) && (st_q.cnt <= CNT_W'(ROWS))); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !rise) |=> st_q.done); // R9
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.pol)); // R6
endmodule

// File: rtl/gsc_level_mux.sv
module gsc_level_mux
    import gsc_pkg::*;
#(
    parameter int ROWS = 241
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ROWS-1:0]         tok,
    input  logic [ROWS-1:0]         act_mask,
    input  logic                    pol,
    input  logic                    row_clk_b,
    output logic [ROWS*SEL_W-1:0]   row_sel
);
    typedef struct packed {
        logic [ROWS-1:0][SEL_W-1:0] sel;
    } mux_state_t;

    mux_state_t      st_d, st_q;
    logic [ROWS-1:0] tok_prev;
    logic [ROWS-1:0] on_vec;

    assign tok_prev = {tok[ROWS-2:0], 1'b0};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ROWS; i++) begin
            if (!act_mask[i])
                st_d.sel[i] = SEL_GND;
            else if (tok[i])
                st_d.sel[i] = (row_clk_b && (i != ROWS - 1)) ? SEL_ON : SEL_OFF;
            else if (tok_prev[i])
                st_d.sel[i] = row_clk_b ? (pol ? SEL_PP_POS : SEL_PP_NEG) : SEL_OFF;
            else
                st_d.sel[i] = SEL_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_sel = st_q.sel;

    for (genvar g = 0; g < ROWS; g++) begin : g_row_chk
        assign on_vec[g] = (st_q.sel[g] == SEL_ON);
        AST_IDLE_BEYOND: assert property (@(posedge clk) disable iff (!rst_n)
            !act_mask[g] |=> (st_q.sel[g] == SEL_GND)); // R7
    end

    AST_SINGLE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(on_vec)); // R4
    AST_LAST_NEVER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sel[ROWS-1] != SEL_ON); // R8
    AST_ON_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !row_clk_b |=> !(|on_vec)); // R4
endmodule

// File: rtl/gate_scan_seq.sv
module gate_scan_seq
    import gsc_pkg::*;
#(
    parameter int ROWS = 241
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        row_clk_a,
    input  logic                        row_clk_b,
    input  logic                        frame_start,
    input  logic                        pulse_pol,
    input  logic [$clog2(ROWS+1)-1:0]   active_rows,
    output logic [ROWS*SEL_W-1:0]       row_sel,
    output logic                        frame_done
);
    logic            rise;
    logic [ROWS-1:0] tok;
    logic [ROWS-1:0] act_mask;
    logic            pol;

    gsc_row_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_clk_a (row_clk_a),
        .rise      (rise)
    );

    gsc_token_chain #(.ROWS(ROWS)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise        (rise),
        .frame_start (frame_start),
        .pulse_pol   (pulse_pol),
        .active_rows (active_rows),
        .tok         (tok),
        .act_mask    (act_mask),
        .pol         (pol),
        .done        (frame_done)
    );

    gsc_level_mux #(.ROWS(ROWS)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok       (tok),
        .act_mask  (act_mask),
        .pol       (pol),
        .row_clk_b (row_clk_b),
        .row_sel   (row_sel)
    );

    AST_DONE_NO_TOKEN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && frame_start) |=> !frame_done); // R9
endmodule

// File: tb/gate_scan_seq_bench.sv
module gate_scan_seq_bench;
    localparam int ROWS = 241;
    localparam int CW   = $clog2(ROWS + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              row_clk_a, row_clk_b, frame_start, pulse_pol;
    logic [CW-1:0]     active_rows;
    logic [ROWS*3-1:0] row_sel;
    logic              frame_done;

    int checks = 0;
    int errors = 0;
    int tok_k  = -1;
    int cnt_e  = ROWS;
    logic pol_e  = 1'b0;
    logic done_e = 1'b0;

    always #2 clk = ~clk;

    gate_scan_seq #(.ROWS(ROWS)) u_gate_scan_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_clk_a   (row_clk_a),
        .row_clk_b   (row_clk_b),
        .frame_start (frame_start),
        .pulse_pol   (pulse_pol),
        .active_rows (active_rows),
        .row_sel     (row_sel),
        .frame_done  (frame_done)
    );

    function automatic logic [2:0] exp_code(int r, int k, int cnt, logic pol, logic b);
        if (r >= cnt)                 return 3'd0;
        if (r == k)                   return (b && r != ROWS - 1) ? 3'd1 : 3'd3;
        if (k >= 0 && r == k + 1)     return b ? (pol ? 3'd2 : 3'd4) : 3'd3;
        return 3'd3;
    endfunction

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic check_rows(logic b, logic in_reset, string tag);
        int bad = -1;
        logic [2:0] e, a;
        for (int r = 0; r < ROWS; r++) begin
            e = in_reset ? 3'd0 : exp_code(r, tok_k, cnt_e, pol_e, b);
            a = row_sel[r*3 +: 3];
            if (a !== e && bad < 0) bad = r;
        end
        checks++;
        if (bad >= 0) begin
            errors++;
            e = in_reset ? 3'd0 : exp_code(bad, tok_k, cnt_e, pol_e, b);
            $display("FAIL %s line %0d token %0d count %0d: actual %0d expected %0d",
                     tag, bad + 1, tok_k + 1, cnt_e, row_sel[bad*3 +: 3], e);
        end
    endtask

    task automatic check_done(logic exp, string tag);
        checks++;
        if (frame_done !== exp) begin
            errors++;
            $display("FAIL %s frame_done actual %0b expected %0b", tag, frame_done, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one row period: capture edge, polarity flip afterwards (R6), window high then low
    task automatic row_step(bit fs, logic pol_in, int req);
        int prev = tok_k;
        @(negedge clk);
        row_clk_a   = 1'b1;
        frame_start = fs;
        pulse_pol   = pol_in;
        active_rows = CW'(req);
        if (fs) begin
            tok_k  = 0;
            cnt_e  = (req == 0) ? 1 : ((req > ROWS) ? ROWS : req);
            done_e = 1'b0;
        end else begin
            done_e = (prev >= 0) && (prev == cnt_e - 1);
            tok_k  = (prev >= 0 && prev + 1 < cnt_e) ? prev + 1 : -1;
        end
        pol_e = pol_in;
        wait_cyc(2);
        row_clk_a   = 1'b0;
        frame_start = 1'b0;
        pulse_pol   = ~pol_in;
        row_clk_b   = 1'b1;
        wait_cyc(3);
        check_rows(1'b1, 1'b0, "R3 R4 R5 R6 R7 R8 window high");
        check_done(done_e, "R9 window high");
        row_clk_b = 1'b0;
        wait_cyc(3);
        check_rows(1'b0, 1'b0, "R4 R5 window low");
    endtask

    task automatic run_frame(int req, logic pol);
        int eff = (req == 0) ? 1 : ((req > ROWS) ? ROWS : req);
        row_step(1, pol, req); // R2
        for (int s = 0; s < eff + 1; s++) row_step(0, pol, req);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 1'b0; row_clk_a = 1'b0; row_clk_b = 1'b1;
        frame_start = 1'b0; pulse_pol = 1'b0; active_rows = CW'(ROWS);
        wait_cyc(4);
        check_rows(1'b1, 1'b1, "R1 reset");
        check_done(1'b0, "R1 reset");
        row_clk_b = 1'b0;
        rst_n = 1'b1;
        wait_cyc(3);
        check_rows(1'b0, 1'b0, "R1 after release");

        run_frame(1, 1'b1);
        run_frame(1, 1'b0);
        run_frame(0, 1'b1);      // R7 count 0 behaves as 1
        run_frame(120, 1'b1);
        run_frame(120, 1'b0);
        run_frame(241, 1'b1);    // R8 token on the last line
        run_frame(241, 1'b0);

        // R2 restart in the middle of a scan
        row_step(1, 1'b1, 50);
        for (int s = 0; s < 7; s++) row_step(0, 1'b1, 50);
        run_frame(50, 1'b0);

        // R1 reset in the middle of a scan with the window open
        row_step(1, 1'b1, 120);
        for (int s = 0; s < 5; s++) row_step(0, 1'b1, 120);
        @(negedge clk);
        row_clk_b = 1'b1;
        rst_n = 1'b0;
        wait_cyc(2);
        check_rows(1'b1, 1'b1, "R1 reset mid-scan");
        check_done(1'b0, "R1 reset mid-scan");
        rst_n = 1'b1;
        tok_k = -1; cnt_e = ROWS; done_e = 1'b0;
        wait_cyc(3);
        check_rows(1'b1, 1'b0, "R1 idle after mid-scan reset");
        row_clk_b = 1'b0;
        run_frame(3, 1'b0);

        report();
    end
endmodule